// File: doc/BRIEF.md
# 10 Mb/s Twisted-Pair Test Tone Generator

This block is a digital pattern source for compliance measurements on a 10 Mb/s twisted-pair transmitter. It drives a square-wave test tone onto one of two transmit dimensions, or onto neither. The block runs from the 20 MHz bit clock. One 3-bit mode code selects both the tone rate and the dimension that carries it. At the bit clock, the fast tone is a 10 MHz square wave and the slow tone is a 5 MHz square wave. The dimension that is not selected stays idle. Line coding, Manchester data and the analog drivers lie outside this block.

Software loads the mode code through a one-cycle write strobe, and may do so at any time. The code goes into a mode register. A tone state machine reads that register, and it adopts a new code only at the end of a complete tone period. A running tone therefore always finishes its low half-period, and no shortened pulse can appear on the line. The register is reset to code 0, which means silence.

The tone state machine has three states:
- `ST_IDLE`: no tone.
- `ST_HIGH`: the high half-period.
- `ST_LOW`: the low half-period.

It has these transitions:
- *start*: `ST_IDLE`→`ST_HIGH`, taken when the stored code is valid.
- *hold*: `ST_IDLE`→`ST_IDLE`, taken when the stored code is not valid.
- *fall*: `ST_HIGH`→`ST_LOW`, taken when the high half-period count ends.
- *restart*: `ST_LOW`→`ST_HIGH`, taken at the end of the low half-period when the stored code is valid. The stored code is loaded as it does so.
- *stop*: `ST_LOW`→`ST_IDLE`, taken at the end of the low half-period when the stored code is not valid.

A half-period lasts one bit clock for the fast tone and `SLOW_HALF` bit clocks for the slow tone.

Top module: `tt_tone_gen`

## Requirements
- R1: While reset is asserted and after it is released, the mode register holds code 0. Until a valid code is written, all four outputs are low.
- R2: Code 3'b001 gives a fast tone on dimension 0. `dim0_level` changes on every bit clock.
- R3: Code 3'b010 gives a fast tone on dimension 1. `dim1_level` changes on every bit clock.
- R4: Code 3'b011 gives a slow tone on dimension 0. `dim0_level` is high for 2 bit clocks and then low for 2 bit clocks (`SLOW_HALF` = 2).
- R5: Code 3'b100 gives a slow tone on dimension 1, with the same 2-high, 2-low pattern on `dim1_level`.
- R6: Codes 0, 5, 6 and 7 give no tone. Both active flags and both levels are low.
- R7: Only the dimension selected by the applied code has its active flag high. The other dimension's level and flag are low.
- R8: When a valid code is written while the generator is idle, the tone starts with its high half-period. The selected level and flag go high after the second rising clock edge that follows the write strobe.
- R9: A code written while a tone runs takes effect only when the current low half-period ends. At that point the new tone starts high, or the outputs go idle. The running period is never shortened.
- R10: When `mode_we` is low, `mode_wdata` has no effect on the mode register or on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | Mode code to store |
| dim0_level | output | 1 | Tone level on dimension 0 |
| dim0_active | output | 1 | Dimension 0 carries a tone |
| dim1_level | output | 1 | Tone level on dimension 1 |
| dim1_active | output | 1 | Dimension 1 carries a tone |

## Verification
A wrong half-period count or a wrong state shows on the level outputs within one tone period, which is at most four bit clocks. It appears as a pulse that is too short, or too long, or a phase that is off. A wrongly applied code shows at the next period boundary: the wrong dimension's flag rises, or the tone rate is wrong. The bench runs every code from idle. It also writes every code on top of each running tone at every phase offset, and compares every output against the period arithmetic on every cycle.

// File: rtl/tt_tone_pkg.sv
package tt_tone_pkg;
    localparam int MODE_W   = 3;
    localparam int NUM_DIMS = 2;
    localparam int DIM_W    = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } tone_state_e;

    typedef struct packed {
        logic             en;
        logic             fast;
        logic [DIM_W-1:0] dim;
    } tone_cfg_t;
endpackage

// File: rtl/tt_mode_decode.sv
module tt_mode_decode
    import tt_tone_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output tone_cfg_t         cfg
);
    always_comb begin
        cfg = '0;
        case (code)
            3'd1: cfg = '{en: 1'b1, fast: 1'b1, dim: 1'b0};
            3'd2: cfg = '{en: 1'b1, fast: 1'b1, dim: 1'b1};
            3'd3: cfg = '{en: 1'b1, fast: 1'b0, dim: 1'b0};
            3'd4: cfg = '{en: 1'b1, fast: 1'b0, dim: 1'b1};
            default: cfg = '0;
        endcase
    end
endmodule

// File: rtl/tt_phase_fsm.sv
module tt_phase_fsm
    import tt_tone_pkg::*;
#(
    parameter int SLOW_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  tone_cfg_t   pend_cfg,
    output tone_state_e state,
    output tone_cfg_t   cur_cfg
);
    localparam int CNT_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);

    tone_state_e     state_d;
    tone_cfg_t       cur_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            half_last;

    assign half_last = cur_cfg.fast ? 1'b1 : (cnt_q == SLOW_LAST);

    always_comb begin
        state_d = state;
        cur_d   = cur_cfg;
        cnt_d   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (pend_cfg.en) begin
                    state_d = ST_HIGH;
                    cur_d   = pend_cfg;
                end else begin
                    cur_d = '0;
                end
            end
            ST_HIGH: begin
                if (half_last) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LOW: begin
                if (half_last) begin
                    cnt_d = '0;
                    if (pend_cfg.en) begin
                        state_d = ST_HIGH;
                        cur_d   = pend_cfg;
                    end else begin
                        state_d = ST_IDLE;
                        cur_d   = '0;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cur_d   = '0;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_cfg <= '0;
            cnt_q   <= '0;
        end else begin
            state   <= state_d;
            cur_cfg <= cur_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/tt_lane_drive.sv
module tt_lane_drive
    import tt_tone_pkg::*;
#(
    parameter int LANE = 0
) (
    input  tone_state_e state,
    input  tone_cfg_t   cur_cfg,
    output logic        level,
    output logic        active
);
    localparam logic [DIM_W-1:0] MY_DIM = DIM_W'(LANE);

    always_comb begin
        active = (state != ST_IDLE) && (cur_cfg.dim == MY_DIM);
        level  = active && (state == ST_HIGH);
    end
endmodule

// File: rtl/tt_tone_gen.sv
module tt_tone_gen
    import tt_tone_pkg::*;
#(
    parameter int SLOW_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [2:0] mode_wdata,
    output logic       dim0_level,
    output logic       dim0_active,
    output logic       dim1_level,
    output logic       dim1_active
);
    logic [MODE_W-1:0] cfg_q;
    tone_cfg_t         pend_cfg;
    tone_cfg_t         cur_cfg;
    tone_state_e       state;
    logic [NUM_DIMS-1:0] lane_level;
    logic [NUM_DIMS-1:0] lane_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q <= '0;
        else if (mode_we) cfg_q <= mode_wdata;
    end

    tt_mode_decode u_dec (
        .code (cfg_q),
        .cfg  (pend_cfg)
    );

    tt_phase_fsm #(.SLOW_HALF(SLOW_HALF)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_cfg (pend_cfg),
        .state    (state),
        .cur_cfg  (cur_cfg)
    );

    for (genvar g = 0; g < NUM_DIMS; g++) begin : g_lane
        tt_lane_drive #(.LANE(g)) u_lane (
            .state   (state),
            .cur_cfg (cur_cfg),
            .level   (lane_level[g]),
            .active  (lane_active[g])
        );
    end

    assign dim0_level  = lane_level[0];
    assign dim0_active = lane_active[0];
    assign dim1_level  = lane_level[1];
    assign dim1_active = lane_active[1];
endmodule

// File: rtl/tt_tone_gen_chk.sv
module tt_tone_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_we,
    input logic [2:0] cfg_code,
    input logic       tone_fast,
    input logic       dim0_level,
    input logic       dim0_active,
    input logic       dim1_level,
    input logic       dim1_active
);
    logic act, lv, code_ok;
    assign act     = dim0_active | dim1_active;
    assign lv      = dim0_level | dim1_level;
    assign code_ok = (cfg_code >= 3'd1) && (cfg_code <= 3'd4);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (cfg_code == 3'd0 && !act && !lv);
        end
    end

    assert_fast_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act && tone_fast && $past(act) && $past(tone_fast)) |-> (lv != $past(lv)));

    assert_slow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !tone_fast && $rose(lv)) |=> lv);

    assert_bad_code_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !code_ok) |=> !act);

    assert_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dim0_active && dim1_active));

    assert_idle_lane_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dim0_active |-> !dim0_level) and (!dim1_active |-> !dim1_level));

    assert_start_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> lv);

    assert_stop_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> !$past(lv));

    assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(cfg_code));
endmodule

bind tt_tone_gen tt_tone_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_we     (mode_we),
    .cfg_code    (cfg_q),
    .tone_fast   (cur_cfg.fast),
    .dim0_level  (dim0_level),
    .dim0_active (dim0_active),
    .dim1_level  (dim1_level),
    .dim1_active (dim1_active)
);

// File: tb/tb_tt_tone_gen.sv
module tb_tt_tone_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = 3'd0;
    logic       dim0_level, dim0_active, dim1_level, dim1_active;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    int s      = 0;
    logic [2:0] cfg_m = 3'd0;
    logic [2:0] app   = 3'd0;
    bit   app_en = 1'b0;
    bit   done   = 1'b0;
    string tag   = "R1";

    always #10 clk = ~clk;

    tt_tone_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .dim0_level(dim0_level), .dim0_active(dim0_active),
        .dim1_level(dim1_level), .dim1_active(dim1_active)
    );

    function automatic bit code_en(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd4);
    endfunction
    function automatic int half_of(input logic [2:0] c);
        return (c == 3'd1 || c == 3'd2) ? 1 : 2;
    endfunction
    function automatic int dim_of(input logic [2:0] c);
        return (c == 3'd2 || c == 3'd4) ? 1 : 0;
    endfunction
    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string t, input int lane, input logic gl, input logic ga,
                       input logic el, input logic ea);
        checks++;
        if (gl !== el || ga !== ea) begin
            fails++;
            $display("FAIL %s lane%0d cycle %0d: level/active got %b/%b expected %b/%b",
                     t, lane, n, gl, ga, el, ea);
        end
    endtask

    task automatic compare();
        for (int lane = 0; lane < 2; lane++) begin
            logic ea, el;
            string t;
            ea = app_en && (dim_of(app) == lane);
            el = ea && (((n - s) / half_of(app)) % 2 == 0);
            t  = tag;
            if (ea && n == s) t = "R8";
            if (!ea && app_en) t = "R7";
            if (lane == 0) chk(t, lane, dim0_level, dim0_active, el, ea);
            else           chk(t, lane, dim1_level, dim1_active, el, ea);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] d);
        mode_we    = we;
        mode_wdata = d;
        @(posedge clk);
        n++;
        if (!app_en) begin
            if (code_en(cfg_m)) begin app = cfg_m; app_en = 1'b1; s = n; end
        end else if (((n - s) % (2 * half_of(app))) == 0) begin
            if (code_en(cfg_m)) begin app = cfg_m; s = n; end
            else app_en = 1'b0;
        end
        if (we) cfg_m = d;
        @(negedge clk);
        compare();
    endtask

    task automatic go_idle();
        step(1'b1, 3'd0);
        repeat (6) step(1'b0, 3'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset and after release
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", 0, dim0_level, dim0_active, 1'b0, 1'b0);
        chk("R1", 1, dim1_level, dim1_active, 1'b0, 1'b0);
        rst_n = 1'b1;
        tag = "R1";
        repeat (4) step(1'b0, 3'd0);

        // R2..R6: every code from idle
        for (int c = 0; c < 8; c++) begin
            tag = tag_of(3'(c));
            step(1'b1, 3'(c));
            repeat (20) step(1'b0, 3'd0);
            tag = "R6";
            go_idle();
        end

        // R9: every code written over every running tone at every phase
        for (int f = 1; f <= 4; f++) begin
            for (int t = 0; t < 8; t++) begin
                for (int off = 0; off < 4; off++) begin
                    tag = "R9";
                    step(1'b1, 3'(f));
                    repeat (5 + off) step(1'b0, 3'd0);
                    step(1'b1, 3'(t));
                    repeat (14) step(1'b0, 3'd0);
                    go_idle();
                end
            end
        end

        // R10: data without strobe is ignored, idle and running
        tag = "R10";
        repeat (8) step(1'b0, 3'd3);
        step(1'b1, 3'd1);
        repeat (3) step(1'b0, 3'd0);
        repeat (10) step(1'b0, 3'd4);
        go_idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule